// File: doc/BRIEF.md
# Three-Mode Core Interrupt Timer

This block is the timer of one core's interrupt controller. It owns a 64-bit timestamp counter that starts at zero after reset and never stops. Software programs it through a small register window: a timer control register with a vector, a mask bit and a mode field, an initial count, a read-only current count, a divide setting and a 64-bit absolute deadline.

In one-shot and periodic mode the timer counts down an interval of initial count times the divide ratio, measured in clock cycles. In deadline mode it instead compares the timestamp counter against the programmed target. The mode field decides which registers are live. When the timer expires and is not masked, the block raises a one-cycle interrupt request that carries the programmed vector. Delivery and prioritisation of that request happen elsewhere.

Top module: `core_irq_timer`

## Requirements
- R1: Register select codes are 0 control, 1 initial count, 2 current count, 3 divide, 4 deadline; any other code reads zero. The control register holds the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17 (00 one-shot, 01 periodic, 10 deadline). All other control bits read zero. After reset the control register reads 0x10000 and the divide code is 0.
- R2: With deadline support disabled by parameter, only mode bit 17 is writable, bit 18 always reads 0, and writes to the deadline register are dropped.
- R3: When `sw_enable` is low, any write to the control register stores the mask bit as 1, whatever the written value.
- R4: A control write whose mode differs from the stored mode disarms both the countdown and the deadline compare at once, so no request follows from the old programming.
- R5: In one-shot or periodic mode, a write of N to the initial count arms the timer, and the request is high in the cycle that follows the N*ratio-th rising edge after the write edge. N=0 does not arm. Each new write restarts the countdown.
- R6: The divide code is {bit 3, bit 1, bit 0} of the written word. Code c selects a ratio of 2^((c+1) mod 8), so codes 0..7 give 2, 4, 8, 16, 32, 64, 128, 1. The register reads the code back in the same bit positions.
- R7: In periodic mode the timer reloads after each expiry and fires every interval cycles. A periodic interval below MIN_PERIOD (default 16) is raised to MIN_PERIOD.
- R8: The current count reads ceil(remaining cycles / ratio) while a countdown runs, and 0 when none is running or the mode is deadline.
- R9: In deadline mode, writes to the initial count are ignored and do not arm a countdown.
- R10: Outside deadline mode, deadline writes are dropped and the deadline register reads 0.
- R11: In deadline mode, a deadline write disarms and re-arms with the new target, and a target of 0 leaves the timer disarmed. The request is high in the cycle after the first edge, at least one edge after the write, at which the timestamp is at or above the target. A target already reached therefore fires one cycle after the write.
- R12: An expiry raises `irq_valid` for exactly one cycle with `irq_vector` set to the stored vector, and only while the mask is clear. A masked expiry still disarms (one-shot, deadline) or reloads (periodic).
- R13: `tsc_now` is 0 in reset and increases by one on every clock edge afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_enable | input | 1 | Controller software-enable; low forces the mask on control writes |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| tsc_now | output | 64 | Timestamp counter |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The inline assertions check, on every cycle, the rules that relate state across a single edge. A mode-changing control write leaves both engines disarmed. A write made with software-enable low leaves the mask set. A request never follows a set mask. A zero count or a zero target does not arm. A periodic expiry keeps the countdown running. Exact expiry cycles under each divide ratio, the periodic minimum, restarts, moving and past deadlines, readback of the mode-dependent registers, and the narrowed mode field with deadline support disabled can only be shown by the bench's scenarios, which compare every cycle against a behavioural model.

// File: rtl/cit_pkg.sv
`timescale 1ns/1ps
// Shared types for the core interrupt timer.
// Assumes: register select is 3 bits and the timer mode field is 2 bits.
package cit_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } tmr_mode_e;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_INIT     = 3'd1,
        SEL_CUR      = 3'd2,
        SEL_DIV      = 3'd3,
        SEL_DEADLINE = 3'd4
    } reg_sel_e;

    localparam int VEC_W    = 8;
    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;
    localparam int MAX_SH   = 7;

    // Divide code c selects a shift of (c+1) mod 8; the 3-bit add wraps on purpose.
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/cit_tsc.sv
`timescale 1ns/1ps
// Free-running timestamp counter.
// Assumes: it wraps silently at 2^W.
module cit_tsc #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Increment once per clock, clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + W'(1);
    end
endmodule

// File: rtl/cit_countdown.sv
`timescale 1ns/1ps
// Cycle-level countdown engine for one-shot and periodic modes.
// Keeps the remaining interval in clock cycles and derives the visible count
// by a ceiling shift with the ratio latched at arm time.
// Assumes: arm and disarm are never high together; periodic intervals >= 2.
module cit_countdown #(
    parameter int CNT_W = 32,
    parameter int IV_W  = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic [IV_W-1:0]  interval,
    input  logic [2:0]       shift,
    input  logic             periodic,
    output logic             expire,
    output logic             running,
    output logic [CNT_W-1:0] cur_count
);
    localparam int SW = IV_W + 1;

    logic [IV_W-1:0] rem_q;
    logic [IV_W-1:0] reload_q;
    logic [2:0]      sh_q;
    logic [SW-1:0]   ceil_sum;
    logic [SW-1:0]   ceil_val;

    // Expiry is the last remaining cycle, unless this edge re-programs the engine.
    always_comb expire = running && (rem_q == IV_W'(1)) && !arm && !disarm;

    // Arm, count down, reload or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            rem_q    <= '0;
            reload_q <= '0;
            sh_q     <= '0;
        end else if (disarm) begin
            running <= 1'b0;
            rem_q   <= '0;
        end else if (arm) begin
            reload_q <= interval;
            sh_q     <= shift;
            rem_q    <= interval;
            running  <= (interval != '0);
        end else if (running) begin
            if (rem_q == IV_W'(1)) begin
                if (periodic) begin
                    rem_q <= reload_q;
                end else begin
                    running <= 1'b0;
                    rem_q   <= '0;
                end
            end else begin
                rem_q <= rem_q - IV_W'(1);
            end
        end
    end

    // Visible count is remaining cycles divided by the ratio, rounded up.
    always_comb begin
        ceil_sum  = {1'b0, rem_q} + ((SW'(1) << sh_q) - SW'(1));
        ceil_val  = ceil_sum >> sh_q;
        cur_count = running ? ceil_val[CNT_W-1:0] : '0;
    end

    // A zero interval never starts the engine.
    assert_zero_nostart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && interval == '0) |=> !running);

    // A periodic expiry keeps the engine running.
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> running);

endmodule

// File: rtl/cit_deadline.sv
`timescale 1ns/1ps
// Absolute-target compare engine for deadline mode.
// Assumes: load is only raised while deadline mode is active.
module cit_deadline #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] target_in,
    input  logic         disarm,
    input  logic [W-1:0] tsc,
    output logic         fire,
    output logic         armed,
    output logic [W-1:0] target
);
    // Fire once the counter has reached or passed the target.
    always_comb fire = armed && (tsc >= target) && !load && !disarm;

    // Load re-arms with the new target; fire or disarm drops the arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            target <= '0;
        end else if (disarm) begin
            armed <= 1'b0;
        end else if (load) begin
            target <= target_in;
            armed  <= (target_in != '0);
        end else if (fire) begin
            armed <= 1'b0;
        end
    end

    // A zero target leaves the engine disarmed.
    assert_zero_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !disarm && target_in == '0) |=> !armed);

endmodule

// File: rtl/core_irq_timer.sv
`timescale 1ns/1ps
// Three-mode core interrupt timer: register decode, mode gating, countdown
// and deadline engines, masking and the registered one-cycle request.
// Assumes: TSC_W >= CNT_W + 8 and >= 19, MIN_PERIOD >= 2.
module core_irq_timer
    import cit_pkg::*;
#(
    parameter int TSC_W       = 64,
    parameter int CNT_W       = 32,
    parameter int MIN_PERIOD  = 16,
    parameter bit DEADLINE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_enable,
    input  logic [2:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [TSC_W-1:0] reg_wdata,
    output logic [TSC_W-1:0] reg_rdata,
    output logic [TSC_W-1:0] tsc_now,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    localparam int         IV_W       = CNT_W + MAX_SH;
    localparam logic [1:0] MODE_WMASK = DEADLINE_EN ? 2'b11 : 2'b01;

    logic [VEC_W-1:0] ctl_vec;
    logic             ctl_mask;
    tmr_mode_e        ctl_mode;
    logic [CNT_W-1:0] init_cnt;
    logic [2:0]       div_code;

    logic             wr_ctl, wr_init, wr_div, wr_dl;
    tmr_mode_e        new_mode;
    logic             mode_chg, in_cd, in_dl;
    logic             cd_arm, dl_load;
    logic [IV_W-1:0]  cd_interval;
    logic             cd_expire, cd_running, dl_fire, dl_armed;
    logic [CNT_W-1:0] cd_cur;
    logic [TSC_W-1:0] dl_target;

    // Write strobes and mode-gating decode.
    always_comb begin
        wr_ctl   = reg_wr && (reg_sel == SEL_CTRL);
        wr_init  = reg_wr && (reg_sel == SEL_INIT);
        wr_div   = reg_wr && (reg_sel == SEL_DIV);
        wr_dl    = reg_wr && (reg_sel == SEL_DEADLINE);
        new_mode = tmr_mode_e'(reg_wdata[MODE_LSB+1:MODE_LSB] & MODE_WMASK);
        mode_chg = wr_ctl && (new_mode != ctl_mode);
        in_cd    = (ctl_mode == MODE_ONESHOT) || (ctl_mode == MODE_PERIODIC);
        in_dl    = (ctl_mode == MODE_DEADLINE);
        cd_arm   = wr_init && in_cd;
        dl_load  = wr_dl && in_dl;
    end

    // Interval in cycles, with the periodic floor applied.
    always_comb begin
        cd_interval = IV_W'(reg_wdata[CNT_W-1:0]) << div_shift(div_code);
        if ((ctl_mode == MODE_PERIODIC) && (cd_interval != '0) &&
            (cd_interval < IV_W'(MIN_PERIOD)))
            cd_interval = IV_W'(MIN_PERIOD);
    end

    // Programmable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_vec  <= '0;
            ctl_mask <= 1'b1;
            ctl_mode <= MODE_ONESHOT;
            init_cnt <= '0;
            div_code <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_vec  <= reg_wdata[VEC_W-1:0];
                ctl_mask <= reg_wdata[MASK_BIT] | !sw_enable;
                ctl_mode <= new_mode;
            end
            if (wr_init && !in_dl) init_cnt <= reg_wdata[CNT_W-1:0];
            if (wr_div)            div_code <= {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
        end
    end

    cit_tsc #(.W(TSC_W)) u_tsc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tsc_now)
    );

    cit_countdown #(.CNT_W(CNT_W), .IV_W(IV_W)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (cd_arm),
        .disarm    (mode_chg),
        .interval  (cd_interval),
        .shift     (div_shift(div_code)),
        .periodic  (ctl_mode == MODE_PERIODIC),
        .expire    (cd_expire),
        .running   (cd_running),
        .cur_count (cd_cur)
    );

    cit_deadline #(.W(TSC_W)) u_dl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dl_load),
        .target_in (reg_wdata),
        .disarm    (mode_chg),
        .tsc       (tsc_now),
        .fire      (dl_fire),
        .armed     (dl_armed),
        .target    (dl_target)
    );

    // Registered request: one cycle per unmasked expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= (cd_expire || dl_fire) && !ctl_mask;
            if (cd_expire || dl_fire) irq_vector <= ctl_vec;
        end
    end

    // Mode-dependent read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[VEC_W-1:0]              = ctl_vec;
                reg_rdata[MASK_BIT]               = ctl_mask;
                reg_rdata[MODE_LSB+1:MODE_LSB]    = ctl_mode;
            end
            SEL_INIT:     reg_rdata = TSC_W'(init_cnt);
            SEL_CUR:      reg_rdata = in_dl ? '0 : TSC_W'(cd_cur);
            SEL_DIV:      reg_rdata = TSC_W'({div_code[2], 1'b0, div_code[1:0]});
            SEL_DEADLINE: reg_rdata = in_dl ? dl_target : '0;
            default:      reg_rdata = '0;
        endcase
    end

    // Control writes with software-enable low leave the mask set.
    assert_mask_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !sw_enable) |=> ctl_mask);

    // No request follows a set mask.
    assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(ctl_mask));

    // A mode change leaves both engines idle.
    assert_modechg_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (!dl_armed && !cd_running));

    // Without deadline support the upper mode bit never sets.
    generate
        if (!DEADLINE_EN) begin : g_nodl
            always_comb begin
                if (rst_n) assert_no_bit18_R2: assert (ctl_mode[1] == 1'b0);
            end
        end
    endgenerate

endmodule

// File: tb/tb_core_irq_timer.sv
`timescale 1ns/1ps
module tb_core_irq_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_enable = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata, tsc_now;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    logic [2:0]  n_sel = '0;
    logic        n_wr = 1'b0;
    logic [63:0] n_wdata = '0;
    logic [63:0] n_rdata, n_tsc;
    logic        n_irq;
    logic [7:0]  n_vec;

    always #2.5 clk = ~clk;

    core_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tsc_now(tsc_now), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    core_irq_timer #(.DEADLINE_EN(1'b0)) dut_nodl (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .reg_sel(n_sel),
        .reg_wr(n_wr), .reg_wdata(n_wdata), .reg_rdata(n_rdata),
        .tsc_now(n_tsc), .irq_valid(n_irq), .irq_vector(n_vec)
    );

    int    tests = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    irq_cnt = 0;
    int    irq_gap = -1;
    int    gap = 0;

    // Behavioural reference state.
    logic [63:0] m_tsc, m_dlt;
    logic [7:0]  m_vec, m_irqv;
    logic        m_mask, m_run, m_dlarm, m_irq;
    logic [1:0]  m_mode;
    logic [31:0] m_init;
    logic [2:0]  m_div, m_sh;
    logic [39:0] m_rem, m_per;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [2:0] s);
        logic [63:0] v;
        v = '0;
        case (s)
            3'd0: v = {45'b0, m_mode, m_mask, 8'b0, m_vec};
            3'd1: v = 64'(m_init);
            3'd2: v = (m_mode == 2'b10 || !m_run) ? 64'd0 :
                      ((64'(m_rem) + (64'd1 << m_sh) - 64'd1) >> m_sh);
            3'd3: v = {60'b0, m_div[2], 1'b0, m_div[1:0]};
            3'd4: v = (m_mode == 2'b10) ? m_dlt : 64'd0;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Reference model advanced on every rising edge from the driven inputs.
    always @(posedge clk) begin
        logic dis, carm, dlw, fcd, fdl;
        logic [1:0]  nm;
        logic [39:0] iv;
        logic [2:0]  nsh;
        if (!rst_n) begin
            m_tsc = 0; m_dlt = 0; m_vec = 0; m_irqv = 0; m_mask = 1; m_run = 0;
            m_dlarm = 0; m_irq = 0; m_mode = 0; m_init = 0; m_div = 0; m_sh = 0;
            m_rem = 0; m_per = 0; gap = 0;
        end else begin
            nm   = reg_wdata[18:17];
            dis  = reg_wr && reg_sel == 3'd0 && nm != m_mode;
            carm = reg_wr && reg_sel == 3'd1 && m_mode < 2'b10;
            dlw  = reg_wr && reg_sel == 3'd4 && m_mode == 2'b10;
            fcd  = m_run && m_rem == 40'd1 && !carm && !dis;
            fdl  = m_dlarm && m_tsc >= m_dlt && !dlw && !dis;
            m_irq = (fcd || fdl) && !m_mask;
            m_irqv = m_vec;
            if (dis) begin
                m_run = 0; m_rem = 0; m_dlarm = 0;
            end else if (carm) begin
                nsh = m_div + 3'd1;
                iv = 40'(reg_wdata[31:0]) << nsh;
                if (m_mode == 2'b01 && iv != 0 && iv < 40'd16) iv = 40'd16;
                m_per = iv; m_rem = iv; m_run = (iv != 0); m_sh = nsh;
            end else if (m_run) begin
                if (m_rem == 40'd1) begin
                    if (m_mode == 2'b01) m_rem = m_per;
                    else begin m_run = 0; m_rem = 0; end
                end else m_rem = m_rem - 40'd1;
            end
            if (dlw) begin
                m_dlt = reg_wdata; m_dlarm = (reg_wdata != 0);
            end else if (fdl) m_dlarm = 0;
            if (reg_wr && reg_sel == 3'd0) begin
                m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16] | !sw_enable; m_mode = nm;
            end
            if (reg_wr && reg_sel == 3'd1 && m_mode != 2'b10) m_init = reg_wdata[31:0];
            if (reg_wr && reg_sel == 3'd3) m_div = {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
            m_tsc = m_tsc + 64'd1;
            gap = reg_wr ? 0 : gap + 1;
        end
    end

    // Compare with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq_valid === m_irq, cur_req, "irq_valid", 64'(irq_valid), 64'(m_irq));
            if (m_irq) check(irq_vector === m_irqv, "R12", "irq_vector", 64'(irq_vector), 64'(m_irqv));
            check(reg_rdata === model_read(reg_sel), cur_req, "reg_rdata", reg_rdata, model_read(reg_sel));
            check(tsc_now === m_tsc, "R13", "tsc_now", tsc_now, m_tsc);
            if (irq_valid) begin
                irq_cnt++;
                irq_gap = gap;
            end
        end
    end

    task automatic drive(input logic [2:0] s, input logic w, input logic [63:0] d);
        reg_sel = s; reg_wr = w; reg_wdata = d;
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [63:0] d);
        drive(s, 1'b1, d);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n, input logic [2:0] s);
        repeat (n) drive(s, 1'b0, 64'd0);
    endtask

    initial begin
        int c0;
        logic [63:0] t;
        idle(3, 3'd0);
        rst_n = 1'b1;

        cur_req = "R1";
        idle(2, 3'd0);
        check(reg_rdata == 64'h10000, "R1", "ctrl after reset", reg_rdata, 64'h10000);
        t = tsc_now;
        idle(5, 3'd3);
        check(tsc_now == t + 5, "R13", "tsc advance", tsc_now, t + 5);
        check(reg_rdata == 64'd0, "R1", "divide after reset", reg_rdata, 64'd0);

        cur_req = "R3";
        sw_enable = 1'b0;
        wr(3'd0, 64'h41);
        idle(1, 3'd0);
        check(reg_rdata == 64'h10041, "R3", "forced mask", reg_rdata, 64'h10041);
        sw_enable = 1'b1;
        wr(3'd0, 64'h41);
        idle(1, 3'd0);
        check(reg_rdata == 64'h41, "R1", "ctrl readback", reg_rdata, 64'h41);

        cur_req = "R5";
        wr(3'd3, 64'hB);
        wr(3'd1, 64'd10);
        c0 = irq_cnt;
        idle(14, 3'd2);
        check(irq_cnt - c0 == 1, "R5", "one-shot count", 64'(irq_cnt - c0), 64'd1);
        check(irq_gap == 10, "R5", "one-shot delay", 64'(irq_gap), 64'd10);
        wr(3'd1, 64'd0);
        c0 = irq_cnt;
        idle(20, 3'd2);
        check(irq_cnt == c0, "R5", "zero count idle", 64'(irq_cnt - c0), 64'd0);
        wr(3'd1, 64'd20);
        idle(5, 3'd2);
        wr(3'd1, 64'd8);
        c0 = irq_cnt;
        idle(14, 3'd2);
        check(irq_cnt - c0 == 1 && irq_gap == 8, "R5", "restart delay", 64'(irq_gap), 64'd8);

        cur_req = "R6";
        wr(3'd3, 64'h0);
        wr(3'd1, 64'd5);
        idle(14, 3'd2);
        check(irq_gap == 10, "R6", "ratio 2", 64'(irq_gap), 64'd10);
        wr(3'd3, 64'h3);
        idle(1, 3'd3);
        check(reg_rdata == 64'h3, "R6", "divide readback", reg_rdata, 64'h3);
        wr(3'd1, 64'd2);
        idle(36, 3'd2);
        check(irq_gap == 32, "R6", "ratio 16", 64'(irq_gap), 64'd32);
        wr(3'd3, 64'h8);
        wr(3'd1, 64'd2);
        idle(70, 3'd2);
        check(irq_gap == 64, "R6", "ratio 32", 64'(irq_gap), 64'd64);

        cur_req = "R8";
        wr(3'd3, 64'hB);
        wr(3'd1, 64'd30);
        idle(10, 3'd2);
        check(reg_rdata == 64'd20, "R8", "current count", reg_rdata, 64'd20);
        idle(25, 3'd2);
        check(reg_rdata == 64'd0, "R8", "count after expiry", reg_rdata, 64'd0);

        cur_req = "R7";
        wr(3'd0, 64'h20041);
        wr(3'd1, 64'd20);
        c0 = irq_cnt;
        idle(65, 3'd2);
        check(irq_cnt - c0 == 3, "R7", "periodic pulses", 64'(irq_cnt - c0), 64'd3);
        check(irq_gap == 60, "R7", "periodic spacing", 64'(irq_gap), 64'd60);
        wr(3'd1, 64'd3);
        c0 = irq_cnt;
        idle(40, 3'd2);
        check(irq_cnt - c0 == 2 && irq_gap == 32, "R7", "minimum period", 64'(irq_gap), 64'd32);

        cur_req = "R12";
        wr(3'd0, 64'h30041);
        c0 = irq_cnt;
        idle(40, 3'd2);
        check(irq_cnt == c0, "R12", "masked quiet", 64'(irq_cnt - c0), 64'd0);
        wr(3'd0, 64'h2005A);
        c0 = irq_cnt;
        for (int i = 0; i < 20 && !irq_valid; i++) idle(1, 3'd2);
        check(irq_valid && irq_vector == 8'h5A, "R12", "vector on request", 64'(irq_vector), 64'h5A);
        idle(1, 3'd2);
        check(!irq_valid, "R12", "single-cycle request", 64'(irq_valid), 64'd0);

        cur_req = "R4";
        wr(3'd0, 64'h41);
        wr(3'd1, 64'd20);
        idle(5, 3'd2);
        wr(3'd0, 64'h20041);
        c0 = irq_cnt;
        idle(40, 3'd2);
        check(irq_cnt == c0, "R4", "mode change disarms", 64'(irq_cnt - c0), 64'd0);
        check(reg_rdata == 64'd0, "R4", "count cleared", reg_rdata, 64'd0);

        cur_req = "R10";
        wr(3'd4, 64'd100);
        idle(1, 3'd4);
        check(reg_rdata == 64'd0, "R10", "deadline hidden", reg_rdata, 64'd0);
        wr(3'd0, 64'h40041);
        idle(1, 3'd4);
        check(reg_rdata == 64'd0, "R10", "dropped write", reg_rdata, 64'd0);

        cur_req = "R9";
        wr(3'd1, 64'd77);
        idle(1, 3'd1);
        check(reg_rdata == 64'd20, "R9", "init unchanged", reg_rdata, 64'd20);
        c0 = irq_cnt;
        idle(10, 3'd2);
        check(reg_rdata == 64'd0, "R8", "count zero in deadline", reg_rdata, 64'd0);
        check(irq_cnt == c0, "R9", "no countdown", 64'(irq_cnt - c0), 64'd0);

        cur_req = "R11";
        t = tsc_now;
        wr(3'd4, t + 30);
        c0 = irq_cnt;
        idle(40, 3'd4);
        check(irq_cnt - c0 == 1 && irq_gap == 30, "R11", "deadline delay", 64'(irq_gap), 64'd30);
        wr(3'd4, 64'd0);
        c0 = irq_cnt;
        idle(20, 3'd4);
        check(irq_cnt == c0, "R11", "zero target", 64'(irq_cnt - c0), 64'd0);
        wr(3'd4, 64'd5);
        c0 = irq_cnt;
        idle(5, 3'd4);
        check(irq_cnt - c0 == 1 && irq_gap == 1, "R11", "past target", 64'(irq_gap), 64'd1);
        t = tsc_now;
        wr(3'd4, t + 50);
        idle(10, 3'd4);
        wr(3'd4, t + 30);
        c0 = irq_cnt;
        idle(60, 3'd4);
        check(irq_cnt - c0 == 1 && irq_gap == 19, "R11", "moved target", 64'(irq_gap), 64'd19);

        cur_req = "R4";
        wr(3'd4, tsc_now + 20);
        idle(3, 3'd4);
        wr(3'd0, 64'h41);
        c0 = irq_cnt;
        idle(30, 3'd4);
        check(irq_cnt == c0, "R4", "deadline disarmed", 64'(irq_cnt - c0), 64'd0);

        n_sel = 3'd0; n_wdata = 64'h60041; n_wr = 1'b1;
        @(negedge clk); #1;
        n_wr = 1'b0;
        @(negedge clk);
        check(n_rdata == 64'h20041, "R2", "bit 18 dropped", n_rdata, 64'h20041);
        #1;
        n_sel = 3'd4; n_wdata = 64'd99; n_wr = 1'b1;
        @(negedge clk); #1;
        n_wr = 1'b0;
        @(negedge clk);
        check(n_rdata == 64'd0, "R2", "deadline unavailable", n_rdata, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule